// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It drives the command pins: clock enable, chip select, row strobe, column strobe, write enable, bank address and row/column address. After reset it walks the memory through the required start-up program and then raises a ready flag. Normal read and write traffic begins only after that flag is high. The block does not run a real impedance calibration flow. It loads the factory-default drive setting and then leaves calibration mode.

The operating contents of the base mode register and of extended registers 1, 2 and 3 come in on input ports. The sequencer forces only the bits the start-up program dictates: the DLL-reset bit (A8), the DLL-disable bit (A0) and the calibration field (A9:A7). All waits are given in clock cycles through parameters. The integrator converts the nanosecond and microsecond limits using the clock period in use. Each gap must be at least 2 cycles.

Every command state lasts one cycle, in which the command is driven. A single down-counter then holds the pins at NOP until the gap for that command has run out. The states and transitions, in order:

- `ST_PWRUP` (clock enable low) goes to `ST_CKE_ON` (clock enable rises).
- `ST_CKE_ON` goes to `ST_PREA_A`, which issues precharge-all.
- `ST_PREA_A` goes to `ST_EMR2`, then `ST_EMR3`.
- `ST_EMR3` goes to `ST_DLL_EN`, then `ST_DLL_RST`.
- `ST_DLL_RST` goes to `ST_PREA_B`, then `ST_REFRESH`. `ST_REFRESH` repeats REFRESH_NUM times.
- The last refresh goes to `ST_MR_OP`, then `ST_OCD_DFLT`.
- `ST_OCD_DFLT` goes to `ST_OCD_EXIT`, then `ST_READY`, which is terminal until reset.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is held, clock enable is low, the command code {cs_n,ras_n,cas_n,we_n} is NOP = 4'b0111, bank and address are zero, and init_done is low.
- R2: Clock enable stays low with NOP for PWRUP_CYC cycles after reset release, then rises and never falls again before the next reset.
- R3: Precharge-all (code 4'b0010, address bit 10 high, all other address bits zero) is issued CKE_WAIT_CYC cycles after clock enable rises.
- R4: Extended register 2 is written (code 4'b0000, bank 2'b10, address = emr2_val) TRP_CYC cycles after the first precharge-all. Extended register 3 follows TMRD_CYC later (bank 2'b11, address = emr3_val).
- R5: TMRD_CYC after the register-3 write, extended register 1 is written with bank 2'b01 and emr1_val, with A0 forced to 0 and A9:A7 forced to 000. This enables the DLL.
- R6: TMRD_CYC later, the base register is written (bank 2'b00) with mr_val and A8 forced high. After TMRD_CYC comes precharge-all, then TRP_CYC later the first of REFRESH_NUM refreshes (code 4'b0001, address zero), each spaced TRFC_CYC apart.
- R7: TRFC_CYC after the last refresh, the base register is written with mr_val and A8 forced low.
- R8: The calibration-default write follows the operating write after the larger of TMRD_CYC and the cycles still missing to reach DLL_LOCK_CYC since the DLL-enable write. It targets bank 2'b01 with emr1_val, A0=0 and A9:A7=111.
- R9: TMRD_CYC later, the calibration-exit write targets bank 2'b01 with emr1_val, A0=0 and A9:A7=000.
- R10: init_done rises exactly one cycle after the calibration-exit command and then stays high with NOP and clock enable high until reset.
- R11: Every cycle that is not one of the commands listed above carries NOP.
- R12: Reset asserted partway through the sequence returns the outputs to the R1 state, and after release the whole sequence restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mr_val | input | ROW_W | Operating base mode register value |
| emr1_val | input | ROW_W | Operating extended register 1 value |
| emr2_val | input | ROW_W | Extended register 2 value |
| emr3_val | input | ROW_W | Extended register 3 value |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row/column/opcode address |
| init_done | output | 1 | Memory ready for normal operation |

## Verification
The hardest case to reach is the one where the calibration-default write is held back by the outstanding DLL lock time rather than by the register-to-register gap. It depends on the total of all gaps since the DLL-enable write. The main instance uses short refresh gaps so that the lock time decides the spacing. A second instance uses long refresh gaps and three refreshes, so the lock time has already run out and the plain register gap applies. A reset partway through the sequence, followed by a complete rerun, exercises the restart.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_CKE_ON,
        ST_PREA_A,
        ST_EMR2,
        ST_EMR3,
        ST_DLL_EN,
        ST_DLL_RST,
        ST_PREA_B,
        ST_REFRESH,
        ST_MR_OP,
        ST_OCD_DFLT,
        ST_OCD_EXIT,
        ST_READY
    } init_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_gap_timer.sv
module ddr2_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] gap,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= gap - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Next command may go out in the cycle after this one.
    assign expire = !load && (cnt <= CNT_W'(1));

    // R11: the wait counts down one per idle cycle
    a_r11_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/ddr2_dll_age.sv
module ddr2_dll_age #(
    parameter int LIMIT = 200,
    parameter int AGE_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [AGE_W-1:0] age
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (start) begin
            age <= AGE_W'(1);
        end else if (age != '0 && age < AGE_W'(LIMIT)) begin
            age <= age + AGE_W'(1);
        end
    end

    // R8: the elapsed count saturates at the lock time
    a_r8_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
        age <= AGE_W'(LIMIT));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int PWRUP_CYC    = 80000,
    parameter int CKE_WAIT_CYC = 160,
    parameter int TRP_CYC      = 5,
    parameter int TMRD_CYC     = 2,
    parameter int TRFC_CYC     = 43,
    parameter int DLL_LOCK_CYC = 200,
    parameter int REFRESH_NUM  = 2,
    parameter int ROW_W        = 14,
    parameter int BANK_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  mr_val,
    input  logic [ROW_W-1:0]  emr1_val,
    input  logic [ROW_W-1:0]  emr2_val,
    input  logic [ROW_W-1:0]  emr3_val,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              init_done
);

    localparam int GAP_MAX = umax(umax(PWRUP_CYC, CKE_WAIT_CYC),
                                  umax(umax(TRP_CYC, TMRD_CYC),
                                       umax(TRFC_CYC, DLL_LOCK_CYC)));
    localparam int CNT_W   = $clog2(GAP_MAX + 1);
    localparam int AGE_W   = $clog2(DLL_LOCK_CYC + 1);
    localparam int REF_W   = $clog2(REFRESH_NUM + 1);

    init_state_e      state, state_nxt;
    logic             issue, issue_nxt;
    logic [REF_W-1:0] ref_left;
    logic [CNT_W-1:0] gap_val;
    logic [CNT_W-1:0] dll_left;
    logic [AGE_W-1:0] dll_age;
    logic             expire;
    logic [3:0]       cmd;

    ddr2_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (issue),
        .gap    (gap_val),
        .expire (expire)
    );

    ddr2_dll_age #(.LIMIT(DLL_LOCK_CYC), .AGE_W(AGE_W)) u_dll (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue && state == ST_DLL_EN),
        .age   (dll_age)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_PWRUP;
            issue    <= 1'b1;
            ref_left <= '0;
        end else begin
            state <= state_nxt;
            issue <= issue_nxt;
            if (issue && state == ST_PREA_B)
                ref_left <= REF_W'(REFRESH_NUM);
            else if (issue && state == ST_REFRESH)
                ref_left <= ref_left - REF_W'(1);
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        issue_nxt = 1'b0;
        if (state == ST_OCD_EXIT && issue) begin
            state_nxt = ST_READY;
        end else if (state != ST_READY && !issue && expire) begin
            issue_nxt = 1'b1;
            unique case (state)
                ST_PWRUP:    state_nxt = ST_CKE_ON;
                ST_CKE_ON:   state_nxt = ST_PREA_A;
                ST_PREA_A:   state_nxt = ST_EMR2;
                ST_EMR2:     state_nxt = ST_EMR3;
                ST_EMR3:     state_nxt = ST_DLL_EN;
                ST_DLL_EN:   state_nxt = ST_DLL_RST;
                ST_DLL_RST:  state_nxt = ST_PREA_B;
                ST_PREA_B:   state_nxt = ST_REFRESH;
                ST_REFRESH:  state_nxt = (ref_left != '0) ? ST_REFRESH : ST_MR_OP;
                ST_MR_OP:    state_nxt = ST_OCD_DFLT;
                ST_OCD_DFLT: state_nxt = ST_OCD_EXIT;
                ST_OCD_EXIT: state_nxt = ST_READY;
                ST_READY:    state_nxt = ST_READY;
                default:     state_nxt = ST_PWRUP;
            endcase
        end
    end

    // Gap that follows the command of the current state
    always_comb begin
        dll_left = (dll_age < AGE_W'(DLL_LOCK_CYC))
                 ? CNT_W'(AGE_W'(DLL_LOCK_CYC) - dll_age) : '0;
        unique case (state)
            ST_PWRUP:                     gap_val = CNT_W'(PWRUP_CYC);
            ST_CKE_ON:                    gap_val = CNT_W'(CKE_WAIT_CYC);
            ST_PREA_A, ST_PREA_B:         gap_val = CNT_W'(TRP_CYC);
            ST_REFRESH:                   gap_val = CNT_W'(TRFC_CYC);
            ST_MR_OP:                     gap_val = (dll_left > CNT_W'(TMRD_CYC))
                                                  ? dll_left : CNT_W'(TMRD_CYC);
            default:                      gap_val = CNT_W'(TMRD_CYC);
        endcase
    end

    // Outputs
    always_comb begin
        cmd       = CMD_NOP;
        ba        = '0;
        addr      = '0;
        cke       = (state != ST_PWRUP);
        init_done = (state == ST_READY);
        if (issue) begin
            unique case (state)
                ST_PREA_A, ST_PREA_B: begin
                    cmd      = CMD_PRE;
                    addr[10] = 1'b1;
                end
                ST_EMR2: begin
                    cmd  = CMD_MRS;
                    ba   = BANK_W'(2);
                    addr = emr2_val;
                end
                ST_EMR3: begin
                    cmd  = CMD_MRS;
                    ba   = BANK_W'(3);
                    addr = emr3_val;
                end
                ST_DLL_EN, ST_OCD_EXIT: begin
                    cmd       = CMD_MRS;
                    ba        = BANK_W'(1);
                    addr      = emr1_val;
                    addr[0]   = 1'b0;
                    addr[9:7] = 3'b000;
                end
                ST_OCD_DFLT: begin
                    cmd       = CMD_MRS;
                    ba        = BANK_W'(1);
                    addr      = emr1_val;
                    addr[0]   = 1'b0;
                    addr[9:7] = 3'b111;
                end
                ST_DLL_RST: begin
                    cmd     = CMD_MRS;
                    addr    = mr_val;
                    addr[8] = 1'b1;
                end
                ST_MR_OP: begin
                    cmd     = CMD_MRS;
                    addr    = mr_val;
                    addr[8] = 1'b0;
                end
                ST_REFRESH: cmd = CMD_REF;
                default:    cmd = CMD_NOP;
            endcase
        end
        {cs_n, ras_n, cas_n, we_n} = cmd;
    end

    // R2: clock enable never falls once raised
    a_r2_cke_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R11: every command is followed by at least one NOP cycle
    a_r11_cmd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R8: calibration default only after the DLL lock time
    a_r8_ocd_after_dll: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && state == ST_OCD_DFLT) |-> (dll_age >= AGE_W'(DLL_LOCK_CYC)));

    // R10: ready is sticky and quiet
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP && cke));

endmodule

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int PWRUP  = 400;
    localparam int CKEW   = 160;
    localparam int TRP    = 5;
    localparam int TMRD   = 2;
    localparam int TRFC   = 43;
    localparam int DLL    = 200;
    localparam int TRFC_B = 150;
    localparam int ROW_W  = 14;
    localparam int NCMD   = 11;

    localparam logic [ROW_W-1:0] MR_V   = 14'h0B53;
    localparam logic [ROW_W-1:0] EMR1_V = 14'h0385;
    localparam logic [ROW_W-1:0] EMR2_V = 14'h0080;
    localparam logic [ROW_W-1:0] EMR3_V = 14'h0003;

    // Expected command stream: code, bank, address, gap from previous event
    localparam logic [3:0] EXP_CODE [NCMD] = '{4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
                                               4'b0010, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000};
    localparam logic [1:0] EXP_BA   [NCMD] = '{2'd0, 2'd2, 2'd3, 2'd1, 2'd0,
                                               2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1};
    localparam logic [ROW_W-1:0] EXP_ADDR [NCMD] = '{14'h0400, EMR2_V, EMR3_V, 14'h0004, 14'h0B53,
                                                     14'h0400, 14'h0000, 14'h0000, 14'h0A53, 14'h0384, 14'h0004};
    localparam int EXP_GAP [NCMD] = '{CKEW, TRP, TMRD, TMRD, TMRD, TMRD, TRP, TRFC, TRFC, 0, TMRD};
    localparam string EXP_REQ [NCMD] = '{"R3", "R4", "R4", "R5", "R6", "R6", "R6", "R6", "R7", "R8", "R9"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0] ba;
    logic [ROW_W-1:0] addr;
    logic cke_b, cs_n_b, ras_n_b, cas_n_b, we_n_b, done_b;
    logic [1:0] ba_b;
    logic [ROW_W-1:0] addr_b;

    ddr2_init_seq #(.PWRUP_CYC(PWRUP), .CKE_WAIT_CYC(CKEW), .TRP_CYC(TRP), .TMRD_CYC(TMRD),
                    .TRFC_CYC(TRFC), .DLL_LOCK_CYC(DLL), .REFRESH_NUM(2), .ROW_W(ROW_W)) uut (
        .clk(clk), .rst_n(rst_n), .mr_val(MR_V), .emr1_val(EMR1_V), .emr2_val(EMR2_V),
        .emr3_val(EMR3_V), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(done));

    ddr2_init_seq #(.PWRUP_CYC(PWRUP), .CKE_WAIT_CYC(CKEW), .TRP_CYC(TRP), .TMRD_CYC(TMRD),
                    .TRFC_CYC(TRFC_B), .DLL_LOCK_CYC(DLL), .REFRESH_NUM(3), .ROW_W(ROW_W)) uut_b (
        .clk(clk), .rst_n(rst_n), .mr_val(MR_V), .emr1_val(EMR1_V), .emr2_val(EMR2_V),
        .emr3_val(EMR3_V), .cke(cke_b), .cs_n(cs_n_b), .ras_n(ras_n_b), .cas_n(cas_n_b), .we_n(we_n_b),
        .ba(ba_b), .addr(addr_b), .init_done(done_b));

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor, main instance
    int cyc, ncmd, cke_cyc, done_cyc, cke_falls;
    int t_log [16];
    logic [3:0] c_log [16];
    logic [1:0] b_log [16];
    logic [ROW_W-1:0] a_log [16];
    // Monitor, second instance
    int cyc_b, refs_b, t_mrop_b, t_ocd_b, nmrs_b;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; ncmd = 0; cke_cyc = -1; done_cyc = -1; cke_falls = 0;
            cyc_b = 0; refs_b = 0; t_mrop_b = -1; t_ocd_b = -1; nmrs_b = 0;
        end else begin
            if (cke && cke_cyc < 0) cke_cyc = cyc;
            if (!cke && cke_cyc >= 0) cke_falls++;
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                if (ncmd < 16) begin
                    t_log[ncmd] = cyc; c_log[ncmd] = {cs_n, ras_n, cas_n, we_n};
                    b_log[ncmd] = ba;  a_log[ncmd] = addr;
                end
                ncmd++;
            end
            if (done && done_cyc < 0) done_cyc = cyc;
            cyc++;
            if ({cs_n_b, ras_n_b, cas_n_b, we_n_b} == 4'b0001) refs_b++;
            if ({cs_n_b, ras_n_b, cas_n_b, we_n_b} == 4'b0000) begin
                nmrs_b++;
                if (nmrs_b == 5) t_mrop_b = cyc_b;
                if (nmrs_b == 6) t_ocd_b = cyc_b;
            end
            cyc_b++;
        end
    end

    task automatic check_reset_state(input string req);
        @(negedge clk);
        check(cke == 1'b0, req, cke, 0);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, {cs_n, ras_n, cas_n, we_n}, 7);
        check(done == 1'b0 && ba == 2'd0 && addr == '0, req, done, 0);
    endtask

    initial begin
        int exp_t;
        int t_dll;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        check_reset_state("R1");
        @(posedge clk); #1 rst_n = 1'b1;

        // run partway, then reset (R12)
        repeat (600) @(posedge clk);
        check(ncmd >= 1 && cke_cyc == PWRUP, "R12 pre-reset progress", cke_cyc, PWRUP);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        check_reset_state("R12");
        @(posedge clk); #1 rst_n = 1'b1;

        // wait for both instances
        while (!(done && done_b)) @(posedge clk);
        repeat (60) @(posedge clk);
        @(negedge clk);

        check(cke_cyc == PWRUP, "R2 cke rise cycle", cke_cyc, PWRUP);
        check(cke_falls == 0, "R2 cke falls", cke_falls, 0);
        check(ncmd == NCMD, "R11 command count", ncmd, NCMD);

        exp_t = PWRUP;
        t_dll = 0;
        for (int i = 0; i < NCMD; i++) begin
            if (i == 9) begin
                exp_t = exp_t + ((DLL - (exp_t - t_dll) > TMRD) ? DLL - (exp_t - t_dll) : TMRD);
            end else begin
                exp_t = exp_t + EXP_GAP[i];
            end
            if (i == 3) t_dll = exp_t;
            if (i < ncmd) begin
                check(t_log[i] == exp_t, {EXP_REQ[i], " cycle"}, t_log[i], exp_t);
                check(c_log[i] == EXP_CODE[i], {EXP_REQ[i], " code"}, c_log[i], EXP_CODE[i]);
                check(b_log[i] == EXP_BA[i], {EXP_REQ[i], " bank"}, b_log[i], EXP_BA[i]);
                check(a_log[i] == EXP_ADDR[i], {EXP_REQ[i], " addr"}, a_log[i], EXP_ADDR[i]);
            end
        end
        check(done_cyc == exp_t + 1, "R10 done cycle", done_cyc, exp_t + 1);
        check(done == 1'b1 && cke == 1'b1, "R10 done held", done, 1);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R10 quiet after done",
              {cs_n, ras_n, cas_n, we_n}, 7);

        // second instance: lock time already elapsed, plain register gap applies
        check(refs_b == 3, "R6 refresh count", refs_b, 3);
        check(t_ocd_b - t_mrop_b == TMRD, "R8 gap without DLL hold", t_ocd_b - t_mrop_b, TMRD);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule